// File: doc/BRIEF.md
# Row Word Source Selector with Frame Tagging

This block decides, once per row period, which 640-bit word goes to the output register that feeds the serializers. The word comes from one of three places: the live discriminator outputs of the current matrix row, one of two programmable test patterns, or a synthetic marker row. Before the word leaves the block, a per-column kill mask clears any disabled columns.

Two test modes change the choice. In pattern-only mode the discriminator data are dropped, and the two patterns take turns by row. In line-marker mode two extra rows follow the last matrix row. Each of them carries one of the patterns, with a one-hot frame tag in the top bits. The tag moves one place to the right every frame, so a receiver can tell when it has slipped a frame.

The tag is resynchronised by a start pulse. Each word is registered on a row-load pulse and marked with a one-cycle valid strobe.

Top module: `rowword_source`

## Requirements
- R1: After reset, `row_word` is all zeros, `row_valid` is 0, and the frame tag holds 10'h200 (only bit 9 set).
- R2: `row_valid` is 1 in exactly the one cycle after each cycle in which `row_load` is 1, and is 0 otherwise. `row_word` changes only in the cycle after a `row_load`.
- R3: With both modes off, the word loaded for any row index is `disc_row`.
- R4: With `pattern_only` set, the word is built from `pat0` when bit 0 of `row_idx` is 0 and from `pat1` when it is 1. The pattern fills bits 629:0 and the frame tag fills bits 639:630. `disc_row` has no effect on the word.
- R5: With `line_marker` set, row index 640 loads {tag, `pat0`} and row index 641 loads {tag, `pat1`}, with the tag in bits 639:630. This holds whatever `pattern_only` is.
- R6: With `line_marker` clear, row indices 640 and 641 are ordinary rows: they give `disc_row`, or a pattern by index parity under `pattern_only`.
- R7: A `sync_start` pulse sets the tag to 10'h200. Each `frame_adv` pulse shifts the tag right by one bit. From 10'h001 the tag wraps to 10'h200. When `sync_start` and `frame_adv` arrive in the same cycle, `sync_start` wins.
- R8: When bit i of `col_disable` is 1, bit i of every loaded word is 0, tag bits included. Bit 639 is the leftmost column.
- R9: With `pat0` = 630'b1010…10 and `pat1` = 630'b0101…01, the first marker rows after a start have 22'h200AAA and 22'h200555 in bits 639:618.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_start | input | 1 | Resynchronise frame tag to its top bit |
| frame_adv | input | 1 | Advance frame tag by one position |
| row_load | input | 1 | Load one row word this cycle |
| row_idx | input | 10 | Index of the row being loaded (0..641) |
| pattern_only | input | 1 | Replace discriminator data by alternating patterns |
| line_marker | input | 1 | Append two tagged marker rows after the matrix |
| disc_row | input | 640 | Discriminator outputs of the current row |
| pat0 | input | 630 | Programmable pattern A |
| pat1 | input | 630 | Programmable pattern B |
| col_disable | input | 640 | Per-column kill mask, 1 clears the column |
| row_word | output | 640 | Registered row word |
| row_valid | output | 1 | One-cycle strobe marking a new row word |

## Verification
The bench builds the block at its default size: 640 columns, 640 matrix rows and a 10-bit tag. This keeps the real row indices 639, 640 and 641 in play, and it lets the 22-bit example readout of R9 be checked at its true bit positions. With a 10-bit tag, a sweep of eleven frame advances covers the whole rotation, including the wrap from the lowest bit back to the top. The mask pattern reaches both the tag field and the pattern field.

// File: rtl/rws_pkg.sv
package rws_pkg;
  // Row word sources, chosen by the decoder and consumed by the word mux.
  typedef enum logic [2:0] {
    SRC_DISC  = 3'd0,
    SRC_PAT0  = 3'd1,
    SRC_PAT1  = 3'd2,
    SRC_MARK0 = 3'd3,
    SRC_MARK1 = 3'd4
  } src_e;
endpackage

// File: rtl/rws_frame_tag.sv
module rws_frame_tag #(
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_start,
  input  logic             frame_adv,
  output logic [TAG_W-1:0] tag
);
  localparam logic [TAG_W-1:0] TAG_TOP = {1'b1, {(TAG_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || sync_start) begin
      tag <= TAG_TOP;
    end else if (frame_adv) begin
      tag <= tag[0] ? TAG_TOP : (tag >> 1);
    end
  end

  // R7
  tag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tag) == 1);
  // R7
  tag_sync_chk: assert property (@(posedge clk) disable iff (rst)
    sync_start |=> tag == TAG_TOP);
  // R7
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_start && !frame_adv) |=> $stable(tag));
endmodule

// File: rtl/rws_src_decode.sv
module rws_src_decode
  import rws_pkg::*;
#(
  parameter int ROWS  = 640,
  parameter int ROW_W = 10
) (
  input  logic [ROW_W-1:0] row_idx,
  input  logic             pattern_only,
  input  logic             line_marker,
  output src_e             src
);
  localparam logic [ROW_W-1:0] MARK_A = ROW_W'(ROWS);
  localparam logic [ROW_W-1:0] MARK_B = ROW_W'(ROWS + 1);

  always_comb begin
    if (line_marker && row_idx == MARK_A) begin
      src = SRC_MARK0;
    end else if (line_marker && row_idx == MARK_B) begin
      src = SRC_MARK1;
    end else if (pattern_only) begin
      src = row_idx[0] ? SRC_PAT1 : SRC_PAT0;
    end else begin
      src = SRC_DISC;
    end
  end
endmodule

// File: rtl/rws_word_mux.sv
module rws_word_mux
  import rws_pkg::*;
#(
  parameter int COLS  = 640,
  parameter int TAG_W = 10,
  localparam int PAT_W = COLS - TAG_W
) (
  input  src_e             src,
  input  logic [TAG_W-1:0] tag,
  input  logic [COLS-1:0]  disc_row,
  input  logic [PAT_W-1:0] pat0,
  input  logic [PAT_W-1:0] pat1,
  input  logic [COLS-1:0]  col_disable,
  output logic [COLS-1:0]  word
);
  logic [COLS-1:0] raw;

  always_comb begin
    unique case (src)
      SRC_PAT0, SRC_MARK0: raw = {tag, pat0};
      SRC_PAT1, SRC_MARK1: raw = {tag, pat1};
      default:             raw = disc_row;
    endcase
  end

  // Column gating, one gate per column.
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign word[c] = raw[c] & ~col_disable[c];
  end
endmodule

// File: rtl/rowword_source.sv
module rowword_source
  import rws_pkg::*;
#(
  parameter int COLS  = 640,
  parameter int ROWS  = 640,
  parameter int TAG_W = 10,
  localparam int ROW_W = $clog2(ROWS + 2),
  localparam int PAT_W = COLS - TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_start,
  input  logic             frame_adv,
  input  logic             row_load,
  input  logic [ROW_W-1:0] row_idx,
  input  logic             pattern_only,
  input  logic             line_marker,
  input  logic [COLS-1:0]  disc_row,
  input  logic [PAT_W-1:0] pat0,
  input  logic [PAT_W-1:0] pat1,
  input  logic [COLS-1:0]  col_disable,
  output logic [COLS-1:0]  row_word,
  output logic             row_valid
);
  logic [TAG_W-1:0] tag;
  src_e             src;
  logic [COLS-1:0]  next_word;

  rws_frame_tag #(.TAG_W(TAG_W)) u_tag (
    .clk        (clk),
    .rst        (rst),
    .sync_start (sync_start),
    .frame_adv  (frame_adv),
    .tag        (tag)
  );

  rws_src_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
    .row_idx      (row_idx),
    .pattern_only (pattern_only),
    .line_marker  (line_marker),
    .src          (src)
  );

  rws_word_mux #(.COLS(COLS), .TAG_W(TAG_W)) u_mux (
    .src         (src),
    .tag         (tag),
    .disc_row    (disc_row),
    .pat0        (pat0),
    .pat1        (pat1),
    .col_disable (col_disable),
    .word        (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_word  <= '0;
      row_valid <= 1'b0;
    end else begin
      row_valid <= row_load;
      if (row_load) begin
        row_word <= next_word;
      end
    end
  end

  // R2
  valid_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
    row_load |=> row_valid);
  // R2
  valid_only_load_chk: assert property (@(posedge clk) disable iff (rst)
    !row_load |=> !row_valid);
  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !row_load |=> $stable(row_word));
  // R8
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    row_load |=> (row_word & $past(col_disable)) == '0);
endmodule

// File: tb/tb_rowword_source.sv
`timescale 1ns/1ps
module tb_rowword_source;
  localparam int COLS = 640;
  localparam int PW   = 630;

  typedef struct packed {
    logic       po;
    logic       lm;
    logic [9:0] idx;
    logic       msk;
  } vec_t;

  // Stimulus table; the expected word of each row comes from exp_word().
  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b0, 10'd0,   1'b0},  // R3
    '{1'b0, 1'b0, 10'd639, 1'b0},  // R3
    '{1'b0, 1'b0, 10'd640, 1'b0},  // R6
    '{1'b1, 1'b0, 10'd0,   1'b0},  // R4
    '{1'b1, 1'b0, 10'd1,   1'b0},  // R4
    '{1'b1, 1'b0, 10'd641, 1'b0},  // R6
    '{1'b0, 1'b1, 10'd640, 1'b0},  // R5
    '{1'b0, 1'b1, 10'd641, 1'b0},  // R5
    '{1'b0, 1'b1, 10'd5,   1'b1},  // R8
    '{1'b1, 1'b1, 10'd640, 1'b1}   // R5 R8
  };

  localparam logic [COLS-1:0] DISC_A = {40{16'h9C3B}};
  localparam logic [COLS-1:0] DISC_B = {40{16'h5E71}};
  localparam logic [PW-1:0]   P0     = {315{2'b10}};
  localparam logic [PW-1:0]   P1     = {315{2'b01}};
  localparam logic [COLS-1:0] MSK    = {40{16'h0F00}};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sync_start = 1'b0;
  logic            frame_adv = 1'b0;
  logic            row_load = 1'b0;
  logic [9:0]      row_idx = '0;
  logic            pattern_only = 1'b0;
  logic            line_marker = 1'b0;
  logic [COLS-1:0] disc_row = DISC_A;
  logic [PW-1:0]   pat0 = P0;
  logic [PW-1:0]   pat1 = P1;
  logic [COLS-1:0] col_disable = '0;
  logic [COLS-1:0] row_word;
  logic            row_valid;

  int checks = 0;
  int fails = 0;
  logic [9:0] exp_tag = 10'h200;

  always #2.5 clk = ~clk;

  rowword_source dut (
    .clk(clk), .rst(rst), .sync_start(sync_start), .frame_adv(frame_adv),
    .row_load(row_load), .row_idx(row_idx), .pattern_only(pattern_only),
    .line_marker(line_marker), .disc_row(disc_row), .pat0(pat0), .pat1(pat1),
    .col_disable(col_disable), .row_word(row_word), .row_valid(row_valid)
  );

  function automatic logic [COLS-1:0] exp_word(input logic po, input logic lm,
      input logic [9:0] idx, input logic [COLS-1:0] m, input logic [9:0] t);
    logic [COLS-1:0] w;
    if (lm && idx == 10'd640)      w = {t, P0};
    else if (lm && idx == 10'd641) w = {t, P1};
    else if (po)                   w = idx[0] ? {t, P1} : {t, P0};
    else                           w = disc_row;
    return w & ~m;
  endfunction

  task automatic check_w(input string req, input logic [COLS-1:0] got,
                         input logic [COLS-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_b(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic load_row(input logic po, input logic lm, input logic [9:0] idx,
                          input logic [COLS-1:0] m);
    @(negedge clk);
    pattern_only = po; line_marker = lm; row_idx = idx; col_disable = m;
    row_load = 1'b1;
    @(negedge clk);
    row_load = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); sync_start = 1'b1;
    @(negedge clk); sync_start = 1'b0;
    exp_tag = 10'h200;
  endtask

  task automatic do_adv();
    @(negedge clk); frame_adv = 1'b1;
    @(negedge clk); frame_adv = 1'b0;
    exp_tag = (exp_tag == 10'h001) ? 10'h200 : (exp_tag >> 1);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [COLS-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_w("R1 reset word", row_word, '0);
    check_b("R1 reset valid", row_valid, 1'b0);
    rst = 1'b0;
    // R1 tag reset value visible on marker row
    load_row(1'b0, 1'b1, 10'd640, '0);
    check_w("R1 tag after reset", row_word, {10'h200, P0});

    // R2 strobe and hold
    check_b("R2 valid after load", row_valid, 1'b1);
    held = row_word;
    @(negedge clk);
    check_b("R2 valid drops", row_valid, 1'b0);
    check_w("R2 word holds", row_word, held);

    // Table walk: R3 R4 R5 R6 R8
    do_sync();
    for (int i = 0; i < 10; i++) begin
      load_row(VEC[i].po, VEC[i].lm, VEC[i].idx, VEC[i].msk ? MSK : '0);
      check_w($sformatf("R3/R4/R5/R6/R8 table row %0d", i), row_word,
              exp_word(VEC[i].po, VEC[i].lm, VEC[i].idx,
                       VEC[i].msk ? MSK : '0, exp_tag));
    end

    // R4 discriminator data ignored under pattern-only
    disc_row = DISC_B;
    load_row(1'b1, 1'b0, 10'd2, '0);
    check_w("R4 disc ignored", row_word, {exp_tag, P0});
    load_row(1'b0, 1'b0, 10'd2, '0);
    check_w("R3 disc second pattern", row_word, DISC_B);

    // R9 example readout in the first frame after start
    do_sync();
    load_row(1'b0, 1'b1, 10'd640, '0);
    check_w("R9 upper bits pat0", {618'b0, row_word[639:618]}, {618'b0, 22'h200AAA});
    load_row(1'b0, 1'b1, 10'd641, '0);
    check_w("R9 upper bits pat1", {618'b0, row_word[639:618]}, {618'b0, 22'h200555});

    // R7 rotation through all positions and wrap
    for (int f = 0; f < 11; f++) begin
      do_adv();
      load_row(1'b0, 1'b1, 10'd640, '0);
      check_w($sformatf("R7 tag step %0d", f), row_word, {exp_tag, P0});
    end

    // R7 start wins over advance
    do_adv();
    @(negedge clk); sync_start = 1'b1; frame_adv = 1'b1;
    @(negedge clk); sync_start = 1'b0; frame_adv = 1'b0;
    exp_tag = 10'h200;
    load_row(1'b0, 1'b1, 10'd641, '0);
    check_w("R7 sync priority", row_word, {10'h200, P1});

    // R8 mask clears the top tag bit on a marker row
    load_row(1'b0, 1'b1, 10'd640, {1'b1, 639'b0});
    check_w("R8 tag bit masked", row_word, {10'h000, P0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule